// File: doc/BRIEF.md
# Flag Offset Loader for a Two-Direction FIFO Pair

This block fills the four programmable flag offsets of a FIFO pair (one FIFO per direction) once a master reset ends. Two of the offsets are almost-full thresholds and two are almost-empty thresholds. The block takes them in one fixed interleaved order, either as whole words from the port A data bus or as a bit stream on a serial data pin qualified by a serial enable. All loading is clocked by the port A clock. The loading method is taken from the mode pins as they stand in the last cycle of reset.

While the sequence is incomplete, the block holds both input-ready flags low and masks every write attempt to either FIFO. When the last bit or word is taken, the port A ready flag rises. The completion is then carried through a two-flop synchronizer into the port C clock domain and raises the port C ready flag there.

The load port has no back-pressure. Every qualified bit or word is taken while the sequence is open. Nothing is taken once it is complete, until the next reset.

Top module: `ofs_loader`

## Requirements
- R1: While `mrst_a` is high at a `clk_a` edge, the load position, all four offsets and `ir_a` are cleared and the mode pins are sampled. The mode used afterwards is the one sampled in the last reset cycle. While `mrst_c` is high at a `clk_c` edge, `ir_c` is cleared. A reset in the middle of a load restarts the sequence from the first offset.
- R2: The load mode is chosen in priority order. `sel_ser_n` = 0 selects serial loading. Otherwise `fs_sel` = 2'b00 selects parallel loading. Any other combination loads nothing: `ir_a` rises at the first `clk_a` edge after reset and the offsets stay 0.
- R3: In serial mode, each `clk_a` edge with `ser_en` = 1 shifts in `ser_d`, for 4·W bits in total. The first bit is the MSB of `ofs_af_a` and the last bit is the LSB of `ofs_ae_a`. The bits fill the offsets in this order: `ofs_af_a`, `ofs_ae_b`, `ofs_af_c`, `ofs_ae_a`, each MSB first.
- R4: In parallel mode, a word is taken at a `clk_a` edge when `a_en` = 1, `a_cs_n` = 0, `a_wr` = 1 and `a_mbx` = 0. Its `a_din[W-1:0]` fills the next offset in the R3 order. The upper bus bits are ignored.
- R5: A cycle that does not qualify a bit or word (enable low, or a qualifier at the wrong level) leaves the load position unchanged. Gaps between items may therefore be of any length.
- R6: `ir_a` rises at the edge that takes the final bit or word, and not before.
- R7: `ir_c` rises on the second `clk_c` edge after `ir_a` rises, or on the third if the first `clk_c` edge coincides with the `ir_a` edge.
- R8: `a_wr_ok` (qualified port A write) is 0 whenever `ir_a` is 0. `c_wr_ok` (port C write, `c_en`) is 0 whenever `ir_c` is 0.
- R9: After completion, further serial bits or parallel words leave all offsets unchanged until the next reset.
- R10: The inputs of the mode not selected have no effect on the offsets.
- R11: Once high, `ir_a` stays high until `mrst_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock; all loading runs on it |
| mrst_a | input | 1 | Master reset, synchronous to clk_a, active high |
| clk_c | input | 1 | Port C clock |
| mrst_c | input | 1 | Master reset, synchronous to clk_c, active high |
| sel_ser_n | input | 1 | Serial load select, active low, sampled during reset |
| fs_sel | input | 2 | Flag-select pins; 2'b00 picks parallel load |
| ser_en | input | 1 | Serial bit enable |
| ser_d | input | 1 | Serial offset data |
| a_en | input | 1 | Port A enable |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | DW | Port A data bus |
| c_en | input | 1 | Port C write attempt |
| ofs_af_a | output | W | Almost-full offset, port A FIFO |
| ofs_ae_b | output | W | Almost-empty offset, port B side |
| ofs_af_c | output | W | Almost-full offset, port C FIFO |
| ofs_ae_a | output | W | Almost-empty offset, port A side |
| ir_a | output | 1 | Port A input ready |
| ir_c | output | 1 | Port C input ready |
| a_wr_ok | output | 1 | Port A FIFO write allowed this cycle |
| c_wr_ok | output | 1 | Port C FIFO write allowed this cycle |

## Verification
The hardest situation to reach is a mode that is decided only by the pin values in the last reset cycle, combined with a stream broken by gaps in which the other mode's inputs are busy. A correct final offset set then proves that neither the gaps nor the foreign inputs moved the load position. The bench holds one mode on the pins for most of the reset, switches to the other in the final cycle, and scrambles the pins after release. It then interleaves every load item with random runs of qualifying traffic for the unused mode. It also checks that the port C ready edge falls inside the two-to-three-edge window measured from the port A edge.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    LD_SER  = 2'd0,
    LD_PAR  = 2'd1,
    LD_NONE = 2'd2
  } ld_mode_e;

  localparam int N_OFS = 4;
endpackage

// File: rtl/ofs_mode_dec.sv
module ofs_mode_dec
  import ofs_pkg::*;
(
  input  logic       sel_ser_n,
  input  logic [1:0] fs_sel,
  output ld_mode_e   mode
);
  always_comb begin
    if (!sel_ser_n)           mode = LD_SER;
    else if (fs_sel == 2'b00) mode = LD_PAR;
    else                      mode = LD_NONE;
  end
endmodule

// File: rtl/ofs_load_core.sv
module ofs_load_core
  import ofs_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 36,
  parameter int VW = N_OFS * W,
  parameter int CW = $clog2(VW + 1)
) (
  input  logic          clk,
  input  logic          mrst,
  input  ld_mode_e      mode_pin,
  input  logic          ser_en,
  input  logic          ser_d,
  input  logic          par_take,
  input  logic [DW-1:0] din,
  output ld_mode_e      mode_q,
  output logic [CW-1:0] pos,
  output logic [VW-1:0] vec,
  output logic          done
);
  localparam logic [CW-1:0] LAST_SER = CW'(VW - 1);
  localparam logic [CW-1:0] LAST_PAR = CW'(N_OFS - 1);

  logic          ser_acc, par_acc;
  logic [VW-1:0] par_vec;
  logic [DW-1:0] unused_din;

  assign unused_din = din;
  assign ser_acc = ser_en & ~done & (mode_q == LD_SER);
  assign par_acc = par_take & ~done & (mode_q == LD_PAR);

  // slot k is the k-th offset in load order, highest slice first
  always_comb begin
    par_vec = vec;
    for (int k = 0; k < N_OFS; k++) begin
      if (pos == CW'(k)) par_vec[VW-1-k*W -: W] = din[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q <= mode_pin;
      pos    <= '0;
      vec    <= '0;
      done   <= 1'b0;
    end else begin
      if (ser_acc) begin
        vec <= {vec[VW-2:0], ser_d};
        pos <= pos + 1'b1;
        if (pos == LAST_SER) done <= 1'b1;
      end else if (par_acc) begin
        vec <= par_vec;
        pos <= pos + 1'b1;
        if (pos == LAST_PAR) done <= 1'b1;
      end else if (mode_q == LD_NONE) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ofs_ready_sync.sv
module ofs_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic mrst,
  input  logic d_in,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (mrst) stg <= '0;
    else      stg <= {stg[STAGES-2:0], d_in};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 36
) (
  input  logic          clk_a,
  input  logic          mrst_a,
  input  logic          clk_c,
  input  logic          mrst_c,
  input  logic          sel_ser_n,
  input  logic [1:0]    fs_sel,
  input  logic          ser_en,
  input  logic          ser_d,
  input  logic          a_en,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_mbx,
  input  logic [DW-1:0] a_din,
  input  logic          c_en,
  output logic [W-1:0]  ofs_af_a,
  output logic [W-1:0]  ofs_ae_b,
  output logic [W-1:0]  ofs_af_c,
  output logic [W-1:0]  ofs_ae_a,
  output logic          ir_a,
  output logic          ir_c,
  output logic          a_wr_ok,
  output logic          c_wr_ok
);
  localparam int VW = N_OFS * W;
  localparam int CW = $clog2(VW + 1);

  ld_mode_e      mode_pin, mode_w;
  logic [CW-1:0] pos_w;
  logic [VW-1:0] vec_w;
  logic          done_w;
  logic          a_write;

  assign a_write = a_en & ~a_cs_n & a_wr & ~a_mbx;

  ofs_mode_dec dec_i (
    .sel_ser_n (sel_ser_n),
    .fs_sel    (fs_sel),
    .mode      (mode_pin)
  );

  ofs_load_core #(.W(W), .DW(DW), .VW(VW), .CW(CW)) core_i (
    .clk      (clk_a),
    .mrst     (mrst_a),
    .mode_pin (mode_pin),
    .ser_en   (ser_en),
    .ser_d    (ser_d),
    .par_take (a_write),
    .din      (a_din),
    .mode_q   (mode_w),
    .pos      (pos_w),
    .vec      (vec_w),
    .done     (done_w)
  );

  ofs_ready_sync #(.STAGES(2)) sync_i (
    .clk  (clk_c),
    .mrst (mrst_c),
    .d_in (done_w),
    .q    (ir_c)
  );

  assign ofs_af_a = vec_w[VW-1 -: W];
  assign ofs_ae_b = vec_w[VW-1-W -: W];
  assign ofs_af_c = vec_w[2*W-1 -: W];
  assign ofs_ae_a = vec_w[W-1:0];

  assign ir_a    = done_w;
  assign a_wr_ok = done_w & a_write;
  assign c_wr_ok = ir_c & c_en;
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk
  import ofs_pkg::*;
#(
  parameter int VW = 32,
  parameter int CW = 6
) (
  input logic          clk_a,
  input logic          mrst_a,
  input logic          clk_c,
  input logic          mrst_c,
  input logic          ser_en,
  input logic          a_en,
  input logic          ir_a,
  input logic          ir_c,
  input logic          a_wr_ok,
  input logic          c_wr_ok,
  input ld_mode_e      mode_q,
  input logic [CW-1:0] pos,
  input logic [VW-1:0] vec
);
  p_ready_hold_r11: assert property (@(posedge clk_a) disable iff (mrst_a)
    ir_a |=> ir_a);

  p_gate_a_r8: assert property (@(posedge clk_a) disable iff (mrst_a)
    !ir_a |-> !a_wr_ok);

  p_gate_c_r8: assert property (@(posedge clk_c) disable iff (mrst_c)
    !ir_c |-> !c_wr_ok);

  p_frozen_r9: assert property (@(posedge clk_a) disable iff (mrst_a)
    ir_a |=> $stable(vec));

  p_idle_r5: assert property (@(posedge clk_a) disable iff (mrst_a)
    (!ser_en && !a_en) |=> $stable(pos));

  p_mode_hold_r2: assert property (@(posedge clk_a) disable iff (mrst_a)
    !mrst_a |=> $stable(mode_q));

  p_ready_order_r7: assert property (@(posedge clk_c) disable iff (mrst_c || mrst_a)
    $rose(ir_c) |-> ir_a);
endmodule

bind ofs_loader ofs_loader_chk #(.VW(VW), .CW(CW)) chk_i (
  .clk_a   (clk_a),
  .mrst_a  (mrst_a),
  .clk_c   (clk_c),
  .mrst_c  (mrst_c),
  .ser_en  (ser_en),
  .a_en    (a_en),
  .ir_a    (ir_a),
  .ir_c    (ir_c),
  .a_wr_ok (a_wr_ok),
  .c_wr_ok (c_wr_ok),
  .mode_q  (mode_w),
  .pos     (pos_w),
  .vec     (vec_w)
);

// File: tb/ofs_loader_tb_top.sv
`timescale 1ns/100ps
module ofs_loader_tb_top;
  localparam int W  = 4;
  localparam int DW = 8;
  localparam int VW = 4 * W;

  logic clk_a = 1'b0, clk_c = 1'b0;
  logic mrst_a = 1'b1, mrst_c = 1'b1;
  logic sel_ser_n = 1'b0;
  logic [1:0] fs_sel = 2'b00;
  logic ser_en = 1'b0, ser_d = 1'b0;
  logic a_en = 1'b0, a_cs_n = 1'b1, a_wr = 1'b0, a_mbx = 1'b0;
  logic [DW-1:0] a_din = '0;
  logic c_en = 1'b0;
  logic [W-1:0] ofs_af_a, ofs_ae_b, ofs_af_c, ofs_ae_a;
  logic ir_a, ir_c, a_wr_ok, c_wr_ok;

  always #5   clk_a = ~clk_a;
  always #6.5 clk_c = ~clk_c;

  ofs_loader #(.W(W), .DW(DW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  realtime t_a = 0.0, t_c = 0.0;

  always @(posedge ir_a) t_a = $realtime;
  always @(posedge ir_c) t_c = $realtime;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    ser_en = 0; ser_d = 0; a_en = 0; a_cs_n = 1; a_wr = 0; a_mbx = 0; a_din = '0; c_en = 0;
  endtask

  task automatic do_reset(input bit sel_e, input logic [1:0] fs_e,
                          input bit sel_l, input logic [1:0] fs_l);
    quiet();
    mrst_a = 1; mrst_c = 1; sel_ser_n = sel_e; fs_sel = fs_e;
    repeat (3) @(negedge clk_a);
    sel_ser_n = sel_l; fs_sel = fs_l;
    @(negedge clk_a);
    mrst_a = 0; mrst_c = 0;
    sel_ser_n = ~sel_l; fs_sel = ~fs_l;   // R1: later pin values must not matter
  endtask

  task automatic check_zero(input string req);
    chk(ir_a == 0, req, ir_a, 0);
    chk(ir_c == 0, req, ir_c, 0);
    chk({ofs_af_a, ofs_ae_b, ofs_af_c, ofs_ae_a} == '0, req,
        {ofs_af_a, ofs_ae_b, ofs_af_c, ofs_ae_a}, 0);
  endtask

  task automatic check_ofs(input logic [VW-1:0] v, input string req);
    chk(ofs_af_a == v[VW-1 -: W],   req, ofs_af_a, v[VW-1 -: W]);
    chk(ofs_ae_b == v[VW-1-W -: W], req, ofs_ae_b, v[VW-1-W -: W]);
    chk(ofs_af_c == v[2*W-1 -: W],  req, ofs_af_c, v[2*W-1 -: W]);
    chk(ofs_ae_a == v[W-1:0],       req, ofs_ae_a, v[W-1:0]);
  endtask

  // serial-mode gap: qualifying parallel traffic that must be ignored (R10, R5)
  task automatic gap_ser();
    quiet();
    a_en = 1; a_cs_n = 0; a_wr = 1; a_mbx = 0; a_din = DW'($urandom); ser_d = 1'($urandom);
    #1;
    if (!ir_a) chk(a_wr_ok == 0, "R8 port A write masked", a_wr_ok, 0);
    @(negedge clk_a);
  endtask

  // parallel-mode gap: non-qualifying words plus serial activity (R5, R10)
  task automatic gap_par();
    quiet();
    ser_en = 1; ser_d = 1'($urandom); a_din = DW'($urandom);
    case ($urandom % 4)
      0: begin a_en = 1; a_cs_n = 1; a_wr = 1; end
      1: begin a_en = 1; a_cs_n = 0; a_wr = 0; end
      2: begin a_en = 1; a_cs_n = 0; a_wr = 1; a_mbx = 1; end
      default: begin a_en = 0; a_cs_n = 0; a_wr = 1; end
    endcase
    @(negedge clk_a);
  endtask

  task automatic ser_bit(input bit b);
    repeat ($urandom % 3) gap_ser();
    quiet(); ser_en = 1; ser_d = b;
    @(negedge clk_a);
    quiet();
  endtask

  task automatic par_word(input logic [W-1:0] v);
    repeat ($urandom % 3) gap_par();
    quiet();
    a_en = 1; a_cs_n = 0; a_wr = 1; a_mbx = 0;
    a_din = {(DW-W)'($urandom), v};
    #1;
    if (!ir_a) chk(a_wr_ok == 0, "R8 load word is not a FIFO write", a_wr_ok, 0);
    @(negedge clk_a);
    quiet();
  endtask

  task automatic check_ready_c();
    realtime d;
    c_en = 1; #1;
    chk(c_wr_ok == 0 || ir_c == 1, "R8 port C write masked", c_wr_ok, 0);
    c_en = 0;
    repeat (5) @(negedge clk_a);
    chk(ir_c == 1, "R7 port C ready raised", ir_c, 1);
    d = t_c - t_a;
    chk(d >= 13.0 && d <= 26.0, "R7 port C ready latency x10ns", longint'(d * 10), 195);
    c_en = 1; #1;
    chk(c_wr_ok == 1, "R8 port C write open", c_wr_ok, 1);
    c_en = 0;
    @(negedge clk_a);
  endtask

  task automatic run_serial(input logic [VW-1:0] v, input bit sel_e, input logic [1:0] fs_e);
    do_reset(sel_e, fs_e, 1'b0, 2'($urandom));
    check_zero("R1 reset state");
    for (int i = VW - 1; i >= 1; i--) ser_bit(v[i]);
    chk(ir_a == 0, "R6 ready low one bit short", ir_a, 0);
    c_en = 1; #1;
    chk(c_wr_ok == 0, "R8 port C masked before load", c_wr_ok, 0);
    c_en = 0;
    ser_bit(v[0]);
    chk(ir_a == 1, "R6 ready after last bit", ir_a, 1);
    check_ofs(v, "R3 R5 R10 serial offsets");
    a_en = 1; a_cs_n = 0; a_wr = 1; #1;
    chk(a_wr_ok == 1, "R8 port A write open", a_wr_ok, 1);
    quiet();
    check_ready_c();
    repeat (3) ser_bit(1'($urandom));
    check_ofs(v, "R9 extra bits ignored");
    chk(ir_a == 1, "R11 ready held", ir_a, 1);
  endtask

  task automatic run_par(input logic [VW-1:0] v, input bit sel_e, input logic [1:0] fs_e);
    do_reset(sel_e, fs_e, 1'b1, 2'b00);
    check_zero("R1 reset state");
    for (int k = 0; k < 3; k++) par_word(v[VW-1-k*W -: W]);
    chk(ir_a == 0, "R6 ready low one word short", ir_a, 0);
    par_word(v[W-1:0]);
    chk(ir_a == 1, "R6 ready after last word", ir_a, 1);
    check_ofs(v, "R4 R5 R10 parallel offsets");
    check_ready_c();
    repeat (2) par_word(W'($urandom));
    check_ofs(v, "R9 extra words ignored");
    chk(ir_a == 1, "R11 ready held", ir_a, 1);
  endtask

  initial begin : wdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk_a);
    check_zero("R1 initial reset");

    // R3 serial sweep: corner patterns then random words
    run_serial('0, 1'b0, 2'b01);
    run_serial('1, 1'b0, 2'b00);
    run_serial(16'hA5C3, 1'b0, 2'b10);
    for (int n = 0; n < 30; n++) run_serial(VW'($urandom), 1'b0, 2'($urandom));

    // R4 parallel sweep: every slot value appears in every slot
    for (int n = 0; n < 16; n++)
      run_par({W'(n), W'(n + 5), W'(n + 10), W'(~n)}, 1'b1, 2'b00);

    // R1 capture: pins say parallel until the last reset cycle, then serial
    run_serial(16'h3C96, 1'b1, 2'b00);
    // R1 capture: pins say serial until the last reset cycle, then parallel
    run_par(16'h7E21, 1'b0, 2'b11);

    // R1 restart: reset in the middle of a serial load
    do_reset(1'b0, 2'b00, 1'b0, 2'b00);
    for (int i = 0; i < 7; i++) ser_bit(1'b1);
    chk(ir_a == 0, "R1 partial load not ready", ir_a, 0);
    run_serial(16'h0F0F, 1'b0, 2'b00);

    // R2 no-load mode
    do_reset(1'b1, 2'b01, 1'b1, 2'b10);
    chk(ir_a == 0, "R2 no-load ready low at release", ir_a, 0);
    @(negedge clk_a);
    chk(ir_a == 1, "R2 no-load ready after one edge", ir_a, 1);
    check_ofs('0, "R2 no-load offsets zero");
    repeat (4) ser_bit(1'b1);
    par_word(4'hF);
    check_ofs('0, "R2 R9 no-load ignores inputs");

    quiet();
    repeat (3) @(negedge clk_a);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule